// File: doc/BRIEF.md
# ATA PIO Sector Command Sequencer

This block is the host-side engine that moves whole sectors between a client and a disk device attached through an ATA task-file register bus. The client hands over one request at a time: a 28-bit logical block address, a sector count from 1 to 256, a drive select (primary or secondary device on the cable) and a direction. The sequencer then programs the task-file registers, checks the device status before it issues the command, and streams 16-bit words. Read words go to the client on a valid/ready output stream. Write words are taken from the client on a valid/ready input stream.

The register bus is a plain single-cycle port: a 3-bit register offset, a read strobe whose data is sampled at the clock edge, and a write strobe with 16-bit write data. A level interrupt line from the device completes each read sector, each written sector and the cache flush. The flush is always issued after the last written sector. When the device reports an error, the sequencer captures the device's error register and ends the request as a failure. Status polling is bounded by a run-time limit, so a device that stays busy ends the request as a timeout instead of stalling the channel.

Top module: `ata_pio_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low on the next cycle.
- R2: After a request is taken, the task file is written in this order, one write per cycle: offset 2 gets the count (256 is written as 0), offsets 3, 4 and 5 get LBA bits 7:0, 15:8 and 23:16, and offset 6 gets 0xE0 OR (drive select << 4) OR LBA bits 27:24. Before the count is written, status (offset 7) is read until BSY (bit 7) is clear.
- R3: The command byte is written to offset 7 only in the cycle that follows a status read showing BSY (bit 7) clear and DRDY (bit 6) set.
- R4: On a read, each sector waits for `dev_irq`, reads status once, and then moves 256 words from offset 0 to `rd_data`. A bus read is made only in a cycle where `rd_valid` and `rd_ready` are both high, so client back-pressure stalls the transfer without losing words.
- R5: On a write, before each sector the sequencer reads status until BSY is clear and DRQ (bit 3) is set. It then writes 256 client words to offset 0, one for each cycle where `wr_valid` and `wr_ready` are both high, and then waits for `dev_irq` and reads status.
- R6: After the last written sector completes without error, 0xE7 is written to offset 7. The sequencer waits for `dev_irq` and reads status before it reports done.
- R7: If status read after an interrupt has ERR (bit 0) set, offset 1 is read. Its low byte is reported on `err_code`, `fail` is high with `done`, and no further bus writes are made for that request.
- R8: If `cfg_poll_limit` consecutive status polls (limit of at least 1) fail their condition, the request ends with `fail` and `timed_out` high, and no bus write follows.
- R9: `done` is high for exactly one cycle per request, and the sequencer is idle (`req_ready` high) in the cycle after. `fail`, `timed_out` and `err_code` stay valid until the next request is taken, and they are zero after a request that succeeds.
- R10: The command byte is 0x20 for a read and 0x30 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_poll_limit | input | LIMIT_W | Maximum consecutive unsatisfied status polls |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_lba | input | 28 | Starting logical block address |
| req_count | input | 9 | Sector count, 1 to 256 |
| req_slave | input | 1 | Selects the second device on the cable |
| req_write | input | 1 | 1 for write, 0 for read |
| wr_valid | input | 1 | Client write word valid |
| wr_ready | output | 1 | Sequencer takes a write word |
| wr_data | input | 16 | Client write word |
| rd_valid | output | 1 | Read word valid |
| rd_ready | input | 1 | Client accepts the read word |
| rd_data | output | 16 | Read word |
| bus_addr | output | 3 | Task-file register offset |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_wdata | output | 16 | Register write data |
| bus_rdata | input | 16 | Register read data, sampled with the strobe |
| dev_irq | input | 1 | Device interrupt, level |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Request ended in failure |
| timed_out | output | 1 | Failure was a polling timeout |
| err_code | output | 8 | Captured device error register |

## Verification
The bench uses the default parameters: 256 words per sector, a 9-bit count and a 16-bit poll limit, driven at run time to 20. With a full-size sector, a 256-sector read exercises the count wrap to 0 and the long stream through both counters. A limit of 20 sits above the device model's four-cycle busy time, so normal polling never trips it, while a device held busy reaches the timeout within a few dozen cycles. Client back-pressure on both streams and a DRDY held low for a while exercise the stall paths against the behavioural device model.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int LBA_W  = 28;
  localparam int WORD_W = 16;

  // task-file register offsets (command block)
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_ERR   = 3'd1;
  localparam logic [2:0] OFS_COUNT = 3'd2;
  localparam logic [2:0] OFS_LBA0  = 3'd3;
  localparam logic [2:0] OFS_LBA1  = 3'd4;
  localparam logic [2:0] OFS_LBA2  = 3'd5;
  localparam logic [2:0] OFS_DRIVE = 3'd6;
  localparam logic [2:0] OFS_CMD   = 3'd7;

  // status bit positions
  localparam int SB_BUSY = 7;
  localparam int SB_RDY  = 6;
  localparam int SB_REQ  = 3;
  localparam int SB_ERR  = 0;

  localparam logic [7:0] OPC_READ  = 8'h20;
  localparam logic [7:0] OPC_WRITE = 8'h30;
  localparam logic [7:0] OPC_FLUSH = 8'hE7;
  localparam logic [7:0] DRIVE_LBA = 8'hE0;

  typedef enum logic [4:0] {
    SQ_IDLE, SQ_POLL_FREE, SQ_TF_COUNT, SQ_TF_LO, SQ_TF_MID, SQ_TF_HI,
    SQ_TF_DRIVE, SQ_POLL_RDY, SQ_ISSUE, SQ_WAIT_INT, SQ_INT_STAT,
    SQ_RD_DATA, SQ_POLL_REQ, SQ_WR_DATA, SQ_FLUSH, SQ_FLUSH_INT,
    SQ_FLUSH_STAT, SQ_GET_ERR, SQ_FINISH
  } sq_state_t;
endpackage

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [LIMIT_W-1:0] limit,
  output logic               expired
);
  logic [LIMIT_W-1:0] cnt_q, cnt_d;
  logic [LIMIT_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    cnt_d   = tick ? cnt_inc[LIMIT_W-1:0] : '0;
    expired = tick && (cnt_inc >= {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ata_xfer_count.sv
module ata_xfer_count #(
  parameter int WPS   = 256,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             word_step,
  input  logic             sec_step,
  output logic             last_word,
  output logic             last_sector
);
  localparam int WW = (WPS > 1) ? $clog2(WPS) : 1;
  localparam logic [WW-1:0] WORD_LAST = WW'(WPS - 1);

  logic [WW-1:0]    word_q, word_d;
  logic [CNT_W-1:0] left_q, left_d;

  assign last_word   = (word_q == WORD_LAST);
  assign last_sector = (left_q == CNT_W'(1));

  always_comb begin
    word_d = word_q;
    if (load)           word_d = '0;
    else if (word_step) word_d = last_word ? '0 : word_q + 1'b1;
    left_d = left_q;
    if (load)          left_d = load_cnt;
    else if (sec_step) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else begin
      word_q <= word_d;
      left_q <= left_d;
    end
  end

  // R4: a sector is retired only while sectors remain
  p_sector_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |-> (left_q != '0));
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int WPS     = 256,
  parameter int CNT_W   = 9,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LIMIT_W-1:0] cfg_poll_limit,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LBA_W-1:0]   req_lba,
  input  logic [CNT_W-1:0]   req_count,
  input  logic               req_slave,
  input  logic               req_write,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [WORD_W-1:0]  wr_data,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [WORD_W-1:0]  rd_data,
  output logic [2:0]         bus_addr,
  output logic               bus_rd,
  output logic               bus_wr,
  output logic [WORD_W-1:0]  bus_wdata,
  input  logic [WORD_W-1:0]  bus_rdata,
  input  logic               dev_irq,
  output logic               done,
  output logic               fail,
  output logic               timed_out,
  output logic [7:0]         err_code
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sq_state_t        state_q, state_d;
  logic [LBA_W-1:0] lba_q;
  logic [7:0]       cnt_lo_q;
  logic             slave_q, write_q;
  logic             fail_q, to_q;
  logic [7:0]       err_q;

  logic       take_req, set_fail, set_to, cap_err;
  logic       word_step, sec_step, last_word, last_sector;
  logic       poll_state, poll_ok, poll_tick, expired;
  logic [7:0] stat;

  assign stat      = bus_rdata[7:0];
  assign rd_data   = bus_rdata;
  assign fail      = fail_q;
  assign timed_out = to_q;
  assign err_code  = err_q;

  // poll condition for each polling state
  always_comb begin
    poll_state = 1'b0;
    poll_ok    = 1'b1;
    case (state_q)
      SQ_POLL_FREE: begin poll_state = 1'b1; poll_ok = !stat[SB_BUSY]; end
      SQ_POLL_RDY:  begin poll_state = 1'b1; poll_ok = !stat[SB_BUSY] && stat[SB_RDY]; end
      SQ_POLL_REQ:  begin poll_state = 1'b1; poll_ok = !stat[SB_BUSY] && stat[SB_REQ]; end
      default: ;
    endcase
  end
  assign poll_tick = poll_state && !poll_ok;

  ata_poll_timer #(.LIMIT_W(LIMIT_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .tick(poll_tick),
    .limit(cfg_poll_limit), .expired(expired)
  );

  ata_xfer_count #(.WPS(WPS), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_int_n), .load(take_req), .load_cnt(req_count),
    .word_step(word_step), .sec_step(sec_step),
    .last_word(last_word), .last_sector(last_sector)
  );

  // next-state and bus decode
  always_comb begin
    state_d   = state_q;
    req_ready = 1'b0;
    rd_valid  = 1'b0;
    wr_ready  = 1'b0;
    bus_addr  = OFS_CMD;
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    take_req  = 1'b0;
    set_fail  = 1'b0;
    set_to    = 1'b0;
    cap_err   = 1'b0;
    word_step = 1'b0;
    sec_step  = 1'b0;
    done      = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          take_req = 1'b1;
          state_d  = SQ_POLL_FREE;
        end
      end
      SQ_POLL_FREE, SQ_POLL_RDY, SQ_POLL_REQ: begin
        bus_rd = 1'b1;
        if (poll_ok) begin
          case (state_q)
            SQ_POLL_FREE: state_d = SQ_TF_COUNT;
            SQ_POLL_RDY:  state_d = SQ_ISSUE;
            default:      state_d = SQ_WR_DATA;
          endcase
        end else if (expired) begin
          set_fail = 1'b1;
          set_to   = 1'b1;
          state_d  = SQ_FINISH;
        end
      end
      SQ_TF_COUNT: begin
        bus_wr = 1'b1; bus_addr = OFS_COUNT; bus_wdata = {8'h00, cnt_lo_q};
        state_d = SQ_TF_LO;
      end
      SQ_TF_LO: begin
        bus_wr = 1'b1; bus_addr = OFS_LBA0; bus_wdata = {8'h00, lba_q[7:0]};
        state_d = SQ_TF_MID;
      end
      SQ_TF_MID: begin
        bus_wr = 1'b1; bus_addr = OFS_LBA1; bus_wdata = {8'h00, lba_q[15:8]};
        state_d = SQ_TF_HI;
      end
      SQ_TF_HI: begin
        bus_wr = 1'b1; bus_addr = OFS_LBA2; bus_wdata = {8'h00, lba_q[23:16]};
        state_d = SQ_TF_DRIVE;
      end
      SQ_TF_DRIVE: begin
        bus_wr = 1'b1; bus_addr = OFS_DRIVE;
        bus_wdata = {8'h00, DRIVE_LBA | {3'b000, slave_q, lba_q[27:24]}};
        state_d = SQ_POLL_RDY;
      end
      SQ_ISSUE: begin
        bus_wr = 1'b1; bus_addr = OFS_CMD;
        bus_wdata = {8'h00, write_q ? OPC_WRITE : OPC_READ};
        state_d = write_q ? SQ_POLL_REQ : SQ_WAIT_INT;
      end
      SQ_WAIT_INT: if (dev_irq) state_d = SQ_INT_STAT;
      SQ_INT_STAT: begin
        bus_rd = 1'b1;
        if (stat[SB_ERR])     state_d = SQ_GET_ERR;
        else if (write_q) begin
          sec_step = 1'b1;
          state_d  = last_sector ? SQ_FLUSH : SQ_POLL_REQ;
        end else              state_d = SQ_RD_DATA;
      end
      SQ_RD_DATA: begin
        rd_valid = 1'b1;
        bus_addr = OFS_DATA;
        bus_rd   = rd_ready;
        if (rd_ready) begin
          word_step = 1'b1;
          if (last_word) begin
            sec_step = 1'b1;
            state_d  = last_sector ? SQ_FINISH : SQ_WAIT_INT;
          end
        end
      end
      SQ_WR_DATA: begin
        wr_ready  = 1'b1;
        bus_addr  = OFS_DATA;
        bus_wr    = wr_valid;
        bus_wdata = wr_data;
        if (wr_valid) begin
          word_step = 1'b1;
          if (last_word) state_d = SQ_WAIT_INT;
        end
      end
      SQ_FLUSH: begin
        bus_wr = 1'b1; bus_addr = OFS_CMD; bus_wdata = {8'h00, OPC_FLUSH};
        state_d = SQ_FLUSH_INT;
      end
      SQ_FLUSH_INT: if (dev_irq) state_d = SQ_FLUSH_STAT;
      SQ_FLUSH_STAT: begin
        bus_rd  = 1'b1;
        state_d = stat[SB_ERR] ? SQ_GET_ERR : SQ_FINISH;
      end
      SQ_GET_ERR: begin
        bus_rd   = 1'b1;
        bus_addr = OFS_ERR;
        cap_err  = 1'b1;
        set_fail = 1'b1;
        state_d  = SQ_FINISH;
      end
      SQ_FINISH: begin
        done    = 1'b1;
        state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // state and request registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= SQ_IDLE;
      lba_q    <= '0;
      cnt_lo_q <= '0;
      slave_q  <= 1'b0;
      write_q  <= 1'b0;
      fail_q   <= 1'b0;
      to_q     <= 1'b0;
      err_q    <= '0;
    end else begin
      state_q <= state_d;
      if (take_req) begin
        lba_q    <= req_lba;
        cnt_lo_q <= req_count[7:0];
        slave_q  <= req_slave;
        write_q  <= req_write;
        fail_q   <= 1'b0;
        to_q     <= 1'b0;
        err_q    <= '0;
      end
      if (set_fail) fail_q <= 1'b1;
      if (set_to)   to_q   <= 1'b1;
      if (cap_err)  err_q  <= stat;
    end
  end

  // R1: a taken request leaves idle at once
  p_accept_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3: data/command writes of an opcode follow a ready status sample
  p_issue_gated_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == OFS_CMD && bus_wdata[7:0] != OPC_FLUSH) |->
      $past(bus_rd && bus_addr == OFS_CMD && !bus_rdata[SB_BUSY] && bus_rdata[SB_RDY]));

  // R4: never both strobes in one cycle
  p_strobe_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bus_rd && bus_wr));

  // R7: a device failure is reported only after the error register was read
  p_error_read_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && fail && !timed_out) |-> $past(bus_rd && bus_addr == OFS_ERR));

  // R8: once timed out, no register write until a new request
  p_quiet_after_timeout_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    timed_out |-> !bus_wr);

  // R9: done is a single-cycle pulse followed by idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> (!done && req_ready));
endmodule

// File: tb/ata_pio_seq_tb_top.sv
module ata_pio_seq_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [15:0] cfg_poll_limit;
  logic        req_valid, req_ready, req_slave, req_write;
  logic [27:0] req_lba;
  logic [8:0]  req_count;
  logic        wr_valid, wr_ready, rd_valid, rd_ready;
  logic [15:0] wr_data, rd_data;
  logic [2:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        dev_irq, done, fail, timed_out;
  logic [7:0]  err_code;

  ata_pio_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_poll_limit(cfg_poll_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_lba(req_lba),
    .req_count(req_count), .req_slave(req_slave), .req_write(req_write),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq(dev_irq),
    .done(done), .fail(fail), .timed_out(timed_out), .err_code(err_code)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [15:0] rpat(int s, int i);
    return {8'(s) ^ 8'hA5, 8'(i)};
  endfunction
  function automatic logic [15:0] wpat(int n);
    return 16'(n * 40503 + 4660);
  endfunction

  // ---------------- behavioural device model ----------------
  localparam int P_NONE = 0, P_RD = 1, P_WRDY = 2, P_WDONE = 3, P_FLUSH = 4;
  logic       bsy_i, drq, errb;
  logic [7:0] err_reg;
  int         busy_cnt, pend, widx, cur_sec, nsect;
  logic       stuck = 1'b0;
  logic       drdy_low = 1'b0;
  int         err_sec = -1;
  logic [7:0] dev_stat;

  always_comb begin
    dev_stat = {bsy_i | stuck, ~drdy_low, 2'b00, drq, 2'b00, errb};
    case (bus_addr)
      3'd7:    bus_rdata = {8'h00, dev_stat};
      3'd1:    bus_rdata = {8'h00, err_reg};
      3'd0:    bus_rdata = rpat(cur_sec, widx);
      default: bus_rdata = 16'h0000;
    endcase
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy_i <= 0; drq <= 0; errb <= 0; dev_irq <= 0; err_reg <= 0;
      busy_cnt <= 0; pend <= P_NONE; widx <= 0; cur_sec <= 0; nsect <= 1;
    end else begin
      if (busy_cnt == 1) begin
        bsy_i <= 0;
        case (pend)
          P_RD: begin
            dev_irq <= 1;
            if (cur_sec == err_sec) begin errb <= 1; err_reg <= 8'h04; end
            else drq <= 1;
          end
          P_WRDY: drq <= 1;
          P_WDONE: begin
            dev_irq <= 1;
            if (cur_sec == err_sec) begin errb <= 1; err_reg <= 8'h10; end
            else begin
              if (cur_sec + 1 < nsect) drq <= 1;
              cur_sec <= cur_sec + 1;
            end
          end
          P_FLUSH: dev_irq <= 1;
          default: ;
        endcase
      end
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (bus_wr) begin
        case (bus_addr)
          3'd2: nsect <= (bus_wdata[7:0] == 8'h00) ? 256 : int'(bus_wdata[7:0]);
          3'd7: begin
            errb <= 0; bsy_i <= 1; busy_cnt <= 4;
            if (bus_wdata[7:0] == 8'hE7) pend <= P_FLUSH;
            else begin
              widx <= 0; cur_sec <= 0;
              pend <= (bus_wdata[7:0] == 8'h30) ? P_WRDY : P_RD;
            end
          end
          3'd0: begin
            if (widx == 255) begin
              widx <= 0; drq <= 0; bsy_i <= 1; busy_cnt <= 4; pend <= P_WDONE;
            end else widx <= widx + 1;
          end
          default: ;
        endcase
      end
      if (bus_rd && bus_addr == 3'd7) dev_irq <= 0;
      if (bus_rd && bus_addr == 3'd0) begin
        if (widx == 255) begin
          widx <= 0; drq <= 0; cur_sec <= cur_sec + 1;
          if (cur_sec + 1 < nsect) begin bsy_i <= 1; busy_cnt <= 4; pend <= P_RD; end
        end else widx <= widx + 1;
      end
    end
  end

  // ---------------- client stream drivers ----------------
  logic rd_bp = 1'b0, wr_bp = 1'b0;
  int   cyc = 0, wcnt = 0, rcnt = 0;
  initial begin
    rd_ready = 1'b1; wr_valid = 1'b0; wr_data = '0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      rd_ready = rd_bp ? (cyc % 4 != 1) : 1'b1;
      wr_valid = wr_bp ? (cyc % 3 != 2) : 1'b1;
      wr_data  = wpat(wcnt);
    end
  end

  // ---------------- reference monitor (every cycle) ----------------
  logic [23:0] exq[$];
  logic [7:0]  last_stat = 8'h00;
  string       wtag = "R2";
  int          wd = 0;

  initial begin
    forever begin
      @(negedge clk);
      wd++;
      if (wd > 190000) begin
        errors++;
        $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 190000)", wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
      if (bus_wr) begin
        logic [23:0] got;
        got = {5'b0, bus_addr, bus_wdata};
        checks++;
        if (exq.size() == 0) begin
          errors++;
          $display("FAIL %s: unexpected bus write actual=%h expected=none", wtag, got);
        end else begin
          logic [23:0] e;
          e = exq.pop_front();
          if (e != got) begin
            errors++;
            $display("FAIL %s: bus write actual=%h expected=%h", wtag, got, e);
          end
        end
        if (bus_addr == 3'd7 && bus_wdata[7:0] != 8'hE7) begin
          checks++; // R3
          if (last_stat[7] || !last_stat[6]) begin
            errors++;
            $display("FAIL R3: command after status actual=%h expected BSY=0 DRDY=1", last_stat);
          end
        end
      end
      if (bus_rd && bus_addr == 3'd7) last_stat = bus_rdata[7:0];
      if (rd_valid && rd_ready) begin
        checks++; // R4
        if (rd_data !== rpat(rcnt / 256, rcnt % 256)) begin
          errors++;
          $display("FAIL R4: read word %0d actual=%h expected=%h", rcnt, rd_data,
                   rpat(rcnt / 256, rcnt % 256));
        end
        rcnt++;
      end
      if (wr_valid && wr_ready) wcnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // queue expected writes and offer a request
  task automatic issue(input logic [27:0] lba, input int cnt, input bit slave,
                       input bit wr, input int esec, input bit tf);
    if (tf) begin
      exq.push_back({8'd2, 8'h00, 8'(cnt)});
      exq.push_back({8'd3, 8'h00, lba[7:0]});
      exq.push_back({8'd4, 8'h00, lba[15:8]});
      exq.push_back({8'd5, 8'h00, lba[23:16]});
      exq.push_back({8'd6, 8'h00, 8'hE0 | {3'b000, slave, lba[27:24]}});
      exq.push_back({8'd7, 8'h00, wr ? 8'h30 : 8'h20});
      if (wr) begin
        int ns;
        ns = (esec >= 0) ? esec + 1 : cnt;
        for (int k = 0; k < ns * 256; k++) exq.push_back({8'd0, wpat(wcnt + k)});
        if (esec < 0) exq.push_back({8'd7, 8'h00, 8'hE7});
      end
    end
    err_sec = esec;
    rcnt = 0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_lba = lba; req_count = 9'(cnt);
    req_slave = slave; req_write = wr;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in idle", int'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b0, "R1 busy after accept", int'(req_ready), 0);
  endtask

  task automatic finish_req(input string tag, input bit efail, input bit eto,
                            input int ecode, input int ewords, output int n);
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
    end
    check(fail == efail, {tag, " fail"}, int'(fail), int'(efail));
    check(timed_out == eto, {tag, " timed_out"}, int'(timed_out), int'(eto));
    check(int'(err_code) == ecode, {tag, " err_code"}, int'(err_code), ecode);
    check(exq.size() == 0, {tag, " pending writes"}, exq.size(), 0);
    if (ewords >= 0) check(rcnt == ewords, {tag, " words read"}, rcnt, ewords);
    @(negedge clk);
    check(done == 1'b0 && req_ready == 1'b1, "R9 single done then idle",
          int'({done, req_ready}), 1);
    exq.delete();
  endtask

  initial begin
    int n;
    rst_n = 1'b0; cfg_poll_limit = 16'd20;
    req_valid = 1'b0; req_lba = '0; req_count = '0; req_slave = 1'b0; req_write = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && done == 1'b0 && !bus_rd && !bus_wr, "R1 reset state",
          int'({req_ready, done, bus_rd, bus_wr}), 8);

    // R2 R3 R4 R10: two-sector read, DRDY held low, client back-pressure
    wtag = "R2 read program"; rd_bp = 1'b1; drdy_low = 1'b1;
    fork begin repeat (10) @(posedge clk); #1 drdy_low = 1'b0; end join_none
    issue(28'h0ABCDEF, 2, 1'b0, 1'b0, -1, 1'b1);
    finish_req("R4 read", 1'b0, 1'b0, 0, 512, n);
    rd_bp = 1'b0;

    // R5 R6 R10: two-sector write to secondary device with gaps on wr_valid
    wtag = "R5 write program"; wr_bp = 1'b1;
    issue(28'h1234567, 2, 1'b1, 1'b1, -1, 1'b1);
    finish_req("R6 write flush", 1'b0, 1'b0, 0, -1, n);
    wr_bp = 1'b0;

    // R2: 256 sectors, count register written as 0
    wtag = "R2 count 256";
    issue(28'h0000100, 256, 1'b0, 1'b0, -1, 1'b1);
    finish_req("R2 full count", 1'b0, 1'b0, 0, 65536, n);

    // R7: read error on second of three sectors
    wtag = "R7 read error";
    issue(28'h0000042, 3, 1'b1, 1'b0, 1, 1'b1);
    finish_req("R7 read error", 1'b1, 1'b0, 8'h04, 256, n);

    // R7: write error on first sector, no flush afterwards
    wtag = "R7 write error";
    issue(28'h0FFFFFF, 2, 1'b0, 1'b1, 0, 1'b1);
    finish_req("R7 write error", 1'b1, 1'b0, 8'h10, -1, n);

    // R8: device stays busy, request times out with no writes at all
    wtag = "R8 timeout"; stuck = 1'b1;
    issue(28'h0000007, 1, 1'b0, 1'b0, -1, 1'b0);
    finish_req("R8 timeout", 1'b1, 1'b1, 0, 0, n);
    check(n >= 19 && n <= 21, "R8 timeout latency", n, 20);
    stuck = 1'b0;

    // R9: status cleared by the next successful request, single-sector write
    wtag = "R9 recovery";
    issue(28'h0000001, 1, 1'b0, 1'b1, -1, 1'b1);
    finish_req("R9 recovery", 1'b0, 1'b0, 0, -1, n);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule